// File: doc/BRIEF.md
# Dual Memory-Mapped Timer/Counter

This peripheral holds one or two identical 32-bit timer channels behind a simple word-addressed register bus. Each channel has three registers: a control/status register, a load register and a counter. A channel counts up or down from the value in its load register. When it reaches its limit, it raises an expiry flag. It then either reloads itself and keeps running, or it stops. The gated expiry flags of all channels combine onto one level-sensitive interrupt line.

Software sets the load value first. It then writes the control register with the enable bit set, which copies the load value into the counter and starts counting. The interrupt handler clears the expiry flag by writing a one to that bit. A build-time parameter removes the second channel, which halves the decoded register space. Only full 32-bit writes exist: the bus has no byte enables. Read data is a combinational function of the address.

Top module: `dual_timer`

## Requirements
- R1: After synchronous reset, every register of every channel reads zero and `irq` is low.
- R2: The word address is decoded as follows. The channel number is `bus_addr >> 2`. Within a channel, slot 0 is control/status (bits 10:0 stored, bits 31:11 read zero), slot 1 is load and slot 2 is the counter. Slot 3 and any address beyond the last channel read zero and ignore writes. Writes to the counter slot are also ignored.
- R3: A control write with bit 7 (enable) set copies the load register into the counter on that edge. Counting starts on the following cycle.
- R4: With bit 1 set (down), an enabled counter decreases by one per cycle. It expires on the cycle in which it holds zero.
- R5: With bit 1 clear (up), an enabled counter increases by one per cycle from the load value. It expires on the cycle in which it holds all-ones, and the counter slot reads back the current up-count.
- R6: Expiry sets bit 8 (flag). A control write with bit 8 at one clears the flag, and with bit 8 at zero it leaves the flag alone. If an expiry and a clear happen in the same cycle, the expiry wins.
- R7: On expiry with bit 4 (auto-reload) set, the counter reloads from the load register and stays enabled. With bit 4 clear, bit 7 clears and the counter holds its final value.
- R8: A control write with bit 7 clear stops the channel. From the next cycle the counter holds its value.
- R9: While bit 5 (load) is set, the counter is forced to the load register value on every cycle.
- R10: A control write with bit 10 set to any channel sets bit 7 in every implemented channel. A channel that was not written keeps its counter value.
- R11: `irq` is high exactly when some implemented channel has both bit 8 (flag) and bit 6 (interrupt enable) set.
- R12: With `SINGLE_CH=1`, only channel 0 exists. Addresses of channel 1 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one full word |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Shared level interrupt |

## Verification
The assertions check the following on every cycle:
- the per-cycle counter step in both directions;
- the stop-and-hold on expiry without auto-reload;
- the counter hold while disabled;
- the forced load;
- the stickiness of the flag between writes;
- the upper control bits and the unused slot reading zero;
- `irq` tracking the gated flags.

Some behaviours only the bench scenarios can show, because they depend on a chosen history of writes:
- the start-from-load on an enable write;
- auto-reload wrapping;
- the clear-by-one semantics;
- enable-all reaching the other channel;
- writes to the counter or unused slots being discarded;
- the single-channel build hiding channel 1.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_W = 11;

    // Control/status layout, bit 10 first (packed MSB first).
    typedef struct packed {
        logic en_all;   // 10
        logic pwm;      // 9  stored only
        logic flag;     // 8
        logic en;       // 7
        logic ie;       // 6
        logic ld;       // 5
        logic arh;      // 4
        logic cap;      // 3  stored only
        logic gen;      // 2  stored only
        logic down;     // 1
        logic mode;     // 0  stored only
    } ctrl_t;

    typedef enum logic [1:0] {
        SLOT_CTRL = 2'd0,
        SLOT_LOAD = 2'd1,
        SLOT_CNT  = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    function automatic logic [CTRL_W-1:0] ctrl_bits(input ctrl_t c);
        return c;
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
    parameter int ADDR_W = 4,
    parameter int NCH    = 2
) (
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic                hit,
    output tmr_pkg::slot_e      slot,
    output logic [ADDR_W-3:0]   chan,
    output logic [NCH-1:0]      wr_ctrl,
    output logic [NCH-1:0]      wr_load
);
    import tmr_pkg::*;

    assign chan = bus_addr[ADDR_W-1:2];
    assign slot = slot_e'(bus_addr[1:0]);
    assign hit  = int'(chan) < NCH;

    for (genvar c = 0; c < NCH; c++) begin : g_sel
        logic mine;
        assign mine       = bus_wr && hit && (int'(chan) == c);
        assign wr_ctrl[c] = mine && (slot == SLOT_CTRL);
        assign wr_load[c] = mine && (slot == SLOT_LOAD);
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_ctrl,
    input  logic                wr_load,
    input  logic                en_all_set,
    input  logic [DATA_W-1:0]   wdata,
    output tmr_pkg::ctrl_t      ctrl,
    output logic [DATA_W-1:0]   cnt,
    output logic [DATA_W-1:0]   load
);
    import tmr_pkg::*;

    ctrl_t             ctrl_q, ctrl_d, wctrl;
    logic [DATA_W-1:0] cnt_q, cnt_d, load_q;
    logic              running, at_limit, expire;

    assign wctrl    = ctrl_t'(wdata[CTRL_W-1:0]);
    assign running  = ctrl_q.en && !ctrl_q.ld;
    assign at_limit = ctrl_q.down ? (cnt_q == '0) : (cnt_q == '1);
    assign expire   = running && at_limit;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_ctrl && wctrl.en) begin
            cnt_d = load_q;
        end else if (ctrl_q.ld) begin
            cnt_d = load_q;
        end else if (running) begin
            if (expire) cnt_d = ctrl_q.arh ? load_q : cnt_q;
            else        cnt_d = ctrl_q.down ? cnt_q - 1'b1 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d      = wctrl;
            ctrl_d.flag = ctrl_q.flag & ~wctrl.flag;
        end else if (expire && !ctrl_q.arh) begin
            ctrl_d.en = 1'b0;
        end
        if (expire)     ctrl_d.flag = 1'b1;
        if (en_all_set) ctrl_d.en   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            load_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            cnt_q  <= cnt_d;
            if (wr_load) load_q <= wdata;
        end
    end

    assign ctrl = ctrl_q;
    assign cnt  = cnt_q;
    assign load = load_q;
endmodule

// File: rtl/tmr_irq_or.sv
module tmr_irq_or #(
    parameter int NCH = 2
) (
    input  tmr_pkg::ctrl_t [NCH-1:0] ctrl,
    output logic                     irq
);
    always_comb begin
        irq = 1'b0;
        for (int c = 0; c < NCH; c++) irq = irq | (ctrl[c].flag & ctrl[c].ie);
    end
endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter bit SINGLE_CH = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import tmr_pkg::*;

    localparam int NCH = SINGLE_CH ? 1 : 2;

    logic                          hit;
    slot_e                         slot;
    logic [ADDR_W-3:0]             chan;
    logic [NCH-1:0]                wr_ctrl, wr_load;
    logic                          en_all_set;
    ctrl_t [NCH-1:0]               ch_ctrl;
    logic [NCH-1:0][DATA_W-1:0]    ch_cnt, ch_load;

    tmr_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .hit     (hit),
        .slot    (slot),
        .chan    (chan),
        .wr_ctrl (wr_ctrl),
        .wr_load (wr_load)
    );

    assign en_all_set = (|wr_ctrl) && bus_wdata[10];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tmr_channel #(.DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_ctrl   (wr_ctrl[c]),
            .wr_load   (wr_load[c]),
            .en_all_set(en_all_set),
            .wdata     (bus_wdata),
            .ctrl      (ch_ctrl[c]),
            .cnt       (ch_cnt[c]),
            .load      (ch_load[c])
        );
    end

    tmr_irq_or #(.NCH(NCH)) u_irq (
        .ctrl(ch_ctrl),
        .irq (irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (hit && int'(chan) == c) begin
                case (slot)
                    SLOT_CTRL: bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_bits(ch_ctrl[c])};
                    SLOT_LOAD: bus_rdata = ch_load[c];
                    SLOT_CNT:  bus_rdata = ch_cnt[c];
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int NCH    = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_wr,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic                       irq,
    input tmr_pkg::ctrl_t [NCH-1:0]   ch_ctrl,
    input logic [NCH-1:0][DATA_W-1:0] ch_cnt,
    input logic [NCH-1:0][DATA_W-1:0] ch_load
);
    logic [NCH-1:0] gated;
    always_comb for (int c = 0; c < NCH; c++) gated[c] = ch_ctrl[c].flag & ch_ctrl[c].ie;

    // R11
    p_irq_match_r11: assert property (@(posedge clk) disable iff (rst)
        irq == (gated != '0));
    // R2
    p_ctrl_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] == 2'd0) |-> (bus_rdata[DATA_W-1:11] == '0));
    p_unused_slot_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] == 2'd3) |-> (bus_rdata == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_p
        // R9
        p_load_force_r9: assert property (@(posedge clk) disable iff (rst)
            (ch_ctrl[c].ld && !bus_wr) |=> (ch_cnt[c] == $past(ch_load[c])));
        // R8
        p_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (!ch_ctrl[c].en && !ch_ctrl[c].ld && !bus_wr) |=> $stable(ch_cnt[c]));
        // R6
        p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            (ch_ctrl[c].flag && !bus_wr) |=> ch_ctrl[c].flag);
        // R4
        p_down_step_r4: assert property (@(posedge clk) disable iff (rst)
            (ch_ctrl[c].en && !ch_ctrl[c].ld && ch_ctrl[c].down && ch_cnt[c] != '0 && !bus_wr)
            |=> (ch_cnt[c] == $past(ch_cnt[c]) - 1'b1));
        // R5
        p_up_step_r5: assert property (@(posedge clk) disable iff (rst)
            (ch_ctrl[c].en && !ch_ctrl[c].ld && !ch_ctrl[c].down && ch_cnt[c] != '1 && !bus_wr)
            |=> (ch_cnt[c] == $past(ch_cnt[c]) + 1'b1));
        // R7
        p_stop_r7: assert property (@(posedge clk) disable iff (rst)
            (ch_ctrl[c].en && !ch_ctrl[c].ld && !ch_ctrl[c].arh && !bus_wr &&
             (ch_ctrl[c].down ? ch_cnt[c] == '0 : ch_cnt[c] == '1))
            |=> (!ch_ctrl[c].en && ch_ctrl[c].flag && $stable(ch_cnt[c])));
    end
endmodule

bind dual_timer tmr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .ch_ctrl  (ch_ctrl),
    .ch_cnt   (ch_cnt),
    .ch_load  (ch_load)
);

// File: tb/tb_dual_timer.sv
`timescale 1ns/1ps
module tb_dual_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_d, rd_s;
    logic        irq_d, irq_s;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dual_timer #(.DATA_W(32), .ADDR_W(4), .SINGLE_CH(1'b0)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_d), .irq(irq_d));

    dual_timer #(.DATA_W(32), .ADDR_W(4), .SINGLE_CH(1'b1)) dut_s (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_s), .irq(irq_s));

    // Reference model: entries 0,1 = two-channel build, entry 2 = single build.
    logic [10:0] mc [3];
    logic [31:0] ml [3];
    logic [31:0] mn [3];

    always @(posedge clk) begin : model
        int nch, base, ch, sl, idx;
        bit ok, ea, wc, wl, run, lim, fire;
        logic [10:0] c, nc;
        logic [31:0] n;
        if (rst) begin
            for (int i = 0; i < 3; i++) begin mc[i] = '0; ml[i] = '0; mn[i] = '0; end
        end else begin
            ch = int'(bus_addr) >> 2;
            sl = int'(bus_addr) & 3;
            for (int m = 0; m < 2; m++) begin
                nch  = (m == 0) ? 2 : 1;
                base = (m == 0) ? 0 : 2;
                ok   = ch < nch;
                ea   = bus_wr && ok && sl == 0 && bus_wdata[10];
                for (int k = 0; k < nch; k++) begin
                    idx  = base + k;
                    c    = mc[idx];
                    nc   = c;
                    n    = mn[idx];
                    wc   = bus_wr && ok && ch == k && sl == 0;
                    wl   = bus_wr && ok && ch == k && sl == 1;
                    run  = c[7] && !c[5];
                    lim  = c[1] ? (mn[idx] == 32'd0) : (mn[idx] == 32'hFFFF_FFFF);
                    fire = run && lim;
                    if (wc && bus_wdata[7]) n = ml[idx];
                    else if (c[5])          n = ml[idx];
                    else if (run) begin
                        if (fire) n = c[4] ? ml[idx] : mn[idx];
                        else      n = c[1] ? mn[idx] - 1 : mn[idx] + 1;
                    end
                    if (wc) begin
                        nc    = bus_wdata[10:0];
                        nc[8] = c[8] & ~bus_wdata[8];
                    end
                    if (fire) begin
                        nc[8] = 1'b1;
                        if (!c[4] && !wc) nc[7] = 1'b0;
                    end
                    if (ea) nc[7] = 1'b1;
                    mn[idx] = n;
                    mc[idx] = nc;
                    if (wl) ml[idx] = bus_wdata;
                end
            end
        end
    end

    function automatic logic [31:0] model_rd(input int m);
        int nch, base, ch, sl;
        nch  = (m == 0) ? 2 : 1;
        base = (m == 0) ? 0 : 2;
        ch   = int'(bus_addr) >> 2;
        sl   = int'(bus_addr) & 3;
        if (ch >= nch) return 32'd0;
        case (sl)
            0: return {21'd0, mc[base + ch]};
            1: return ml[base + ch];
            2: return mn[base + ch];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic model_irq(input int m);
        logic r;
        r = 1'b0;
        if (m == 0) for (int i = 0; i < 2; i++) r = r | (mc[i][8] & mc[i][6]);
        else        r = mc[2][8] & mc[2][6];
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison, 1 ns after the active edge.
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            check(cur_req, "rdata dual",  rd_d, model_rd(0));
            check(cur_req, "rdata single", rd_s, model_rd(1));
            check(cur_req, "irq dual",   {31'd0, irq_d}, {31'd0, model_irq(0)});
            check(cur_req, "irq single", {31'd0, irq_s}, {31'd0, model_irq(1)});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic look(input logic [3:0] a, input string req, input string what,
                        input logic [31:0] exp_d, input logic [31:0] exp_s);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, {what, " dual"}, rd_d, exp_d);
        check(req, {what, " single"}, rd_s, exp_s);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        cur_req = "R1";
        look(4'd0, "R1", "ctrl0", 32'd0, 32'd0);
        look(4'd1, "R1", "load0", 32'd0, 32'd0);
        look(4'd6, "R1", "cnt1",  32'd0, 32'd0);
        check("R1", "irq", {31'd0, irq_d}, 32'd0);

        // R2: upper bits of control not stored
        cur_req = "R2";
        wr(4'd0, 32'hFFFF_F003);
        look(4'd0, "R2", "ctrl upper bits", 32'h0000_0003, 32'h0000_0003);

        // R3, R4, R7, R11: down count from 3, no reload
        cur_req = "R4";
        wr(4'd1, 32'd3);
        wr(4'd0, 32'h0000_00C2);
        idle(5);
        check("R11", "irq after down expiry", {31'd0, irq_d}, 32'd1);
        look(4'd0, "R7", "ctrl after stop", 32'h0000_0142, 32'h0000_0142);
        look(4'd2, "R4", "cnt held at zero", 32'd0, 32'd0);

        // R6: writing 0 to flag keeps it, writing 1 clears it
        cur_req = "R6";
        wr(4'd0, 32'h0000_0042);
        look(4'd0, "R6", "flag kept", 32'h0000_0142, 32'h0000_0142);
        wr(4'd0, 32'h0000_0142);
        look(4'd0, "R6", "flag cleared", 32'h0000_0042, 32'h0000_0042);
        check("R11", "irq cleared", {31'd0, irq_d}, 32'd0);

        // R5, R7: up count with auto-reload on channel 1
        cur_req = "R5";
        wr(4'd5, 32'hFFFF_FF00);
        wr(4'd4, 32'h0000_00D0);
        idle(260);
        look(4'd4, "R7", "ch1 reload keeps enable", 32'h0000_01D0, 32'h0);
        check("R11", "irq from ch1", {31'd0, irq_d}, 32'd1);

        // R8: stop by clearing enable, also clear flag
        cur_req = "R8";
        wr(4'd4, 32'h0000_0150);
        look(4'd4, "R8", "ch1 stopped", 32'h0000_0050, 32'h0);
        idle(5);

        // R10: enable-all from channel 0 starts channel 1
        cur_req = "R10";
        wr(4'd0, 32'h0000_0400);
        look(4'd4, "R10", "ch1 enabled by ch0", 32'h0000_00D0, 32'h0);
        look(4'd0, "R10", "ch0 enabled", 32'h0000_0480, 32'h0000_0480);
        wr(4'd4, 32'h0000_0000);
        wr(4'd0, 32'h0000_0000);

        // R9: load bit forces counter
        cur_req = "R9";
        wr(4'd0, 32'h0000_0020);
        wr(4'd1, 32'h0000_1234);
        idle(2);
        look(4'd2, "R9", "cnt follows load", 32'h0000_1234, 32'h0000_1234);

        // R2: counter slot, slot 3 and out-of-range writes ignored
        cur_req = "R2";
        wr(4'd2, 32'h0000_0055);
        look(4'd2, "R2", "cnt write ignored", 32'h0000_1234, 32'h0000_1234);
        wr(4'd3, 32'hDEAD_BEEF);
        look(4'd3, "R2", "slot3 reads zero", 32'd0, 32'd0);
        wr(4'd9, 32'hCAFE_F00D);
        look(4'd9, "R2", "out of range", 32'd0, 32'd0);

        // R12: single build hides channel 1
        cur_req = "R12";
        wr(4'd5, 32'h0000_ABCD);
        look(4'd5, "R12", "ch1 load", 32'h0000_ABCD, 32'd0);
        wr(4'd0, 32'h0000_0000);

        // R3: enable write loads counter, then counts down
        cur_req = "R3";
        wr(4'd1, 32'd100);
        wr(4'd0, 32'h0000_0082);
        look(4'd2, "R3", "cnt after start", 32'd99, 32'd99);
        idle(110);
        look(4'd0, "R7", "ie off flag", 32'h0000_0102, 32'h0000_0102);
        check("R11", "irq masked", {31'd0, irq_s}, 32'd0);

        idle(3);
        summary();
    end
endmodule